// File: doc/BRIEF.md
# Cascadable Serial Configuration Bitstream Reader

This block is the read side of a one-bit-wide configuration store that an SRAM FPGA pulls its bitstream from in master serial mode. A parameterized bit array is filled through a simple write port that works only in programming mode. After that, each rising clock edge steps a bit counter while the device is selected and its output is enabled, and the bit at the counter position is presented on a three-state data output.

Several readers can be chained. The chip-enable output of one reader feeds the active-low chip-enable input of the next. When a reader has shifted out its last bit, it releases its data line and pulls its chip-enable output low, so the next reader can take over. A shared pin serves both as reset and as output enable. Its sense is chosen by a configuration input. The three-state output is modelled as a data value plus a separate drive-enable.

Top module: `cfg_bit_reader`

## Requirements
- R1: An active-low power-on reset clears the bit counter, so once it is released the first bit presented is the one at position 0.
- R2: At the reset level of the reset/enable pin, the counter returns to 0 at the next clock edge. While the pin is at that level, the data output is not driven and the chain output is high, whatever the chip-enable input does.
- R3: With `rstActiveHigh` = 0, the reset level of the pin is low and a high level enables the output. With `rstActiveHigh` = 1, both senses are inverted.
- R4: The counter advances by one on a clock edge only when `serEn` = 1, `ceN` = 0 and the output is enabled. `dataOe` is 1 under exactly those conditions, until the memory is exhausted.
- R5: While `ceN` = 1, the counter holds its value and `dataOe` = 0, whatever the reset/enable pin does (apart from the reset of R2).
- R6: While driven, `dataOut` equals the stored bit at the current counter position.
- R7: The clock edge that shifts out bit DEPTH-1 marks the memory as exhausted. From then on `dataOe` = 0, and `ceoN` = 0 while `ceN` = 0 and the output is enabled.
- R8: After exhaustion, `ceoN` follows `ceN` for as long as the output stays enabled. Once the pin goes to its reset level, `ceoN` stays high until the whole memory has been read out again.
- R9: With `serEn` = 0 (programming mode), `dataOe` = 0, `ceoN` = 1, `ceN` has no effect and the counter holds its value. Writes through `prgWe` take effect only in this mode and are ignored when `serEn` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; rising edge steps the counter |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| rstActiveHigh | input | 1 | Reset/enable pin sense: 0 = reset when low, 1 = reset when high |
| rstOePin | input | 1 | Combined reset / output-enable pin |
| ceN | input | 1 | Chip enable, active low |
| serEn | input | 1 | 1 = read mode, 0 = programming mode |
| prgWe | input | 1 | Preload write strobe (programming mode only) |
| prgAddr | input | ADDR_W | Preload bit address |
| prgBit | input | 1 | Preload bit value |
| dataOut | output | 1 | Serial data value (0 when not driven) |
| dataOe | output | 1 | Drive enable for the data line |
| ceoN | output | 1 | Chip-enable output to the next reader, active low |

## Verification
A counter that is off by one would show up at once as a wrong bit on `dataOut` in the first driven cycle after the fault. A wrong exhausted flag would show up as `ceoN` falling one edge early or late, or as the data line still driven after bit DEPTH-1. Both appear within a single clock of the boundary. The chain handoff is checked across the full follow-then-release sequence, because a flag that is never cleared would be visible only on the second read-out.

// File: rtl/cfg_bit_reader_pkg.sv
package cfg_bit_reader_pkg;
  // Strobes issued by the control block to the bit-counter datapath
  typedef struct packed {
    logic clear;    // return counter to position 0
    logic advance;  // step counter by one position
  } ctlStrobes_t;
endpackage

// File: rtl/cfg_bit_reader_dp.sv
module cfg_bit_reader_dp
  import cfg_bit_reader_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              porN,
  input  ctlStrobes_t       strobes,
  input  logic              progMode,
  input  logic              prgWe,
  input  logic [ADDR_W-1:0] prgAddr,
  input  logic              prgBit,
  output logic [ADDR_W-1:0] bitPos,
  output logic              atLast,
  output logic              curBit
);
  localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(DEPTH - 1);

  logic [DEPTH-1:0] bitStore;

  // Preload path: accepted only in programming mode
  always_ff @(posedge clk) begin
    if (prgWe && progMode) bitStore[prgAddr] <= prgBit;
  end

  // Bit counter: parks on the last position; exhaustion is tracked by control
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                          bitPos <= '0;
    else if (strobes.clear)             bitPos <= '0;
    else if (strobes.advance && !atLast) bitPos <= bitPos + 1'b1;
  end

  assign atLast = (bitPos == LAST_POS);
  assign curBit = bitStore[bitPos];
endmodule

// File: rtl/cfg_bit_reader_ctl.sv
module cfg_bit_reader_ctl
  import cfg_bit_reader_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        rstActiveHigh,
  input  logic        rstOePin,
  input  logic        ceN,
  input  logic        serEn,
  input  logic        atLast,
  output ctlStrobes_t strobes,
  output logic        driveEn,
  output logic        ceoN
);
  logic resetLvl;
  logic readSel;
  logic exhausted;

  // Configurable pin sense: reset level vs. output-enable level
  assign resetLvl = rstActiveHigh ? rstOePin : ~rstOePin;
  assign readSel  = serEn & ~ceN & ~resetLvl;

  assign strobes.clear   = resetLvl;
  assign strobes.advance = readSel & ~exhausted;

  // Set on the edge that shifts out the final bit, cleared by the reset level
  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                       exhausted <= 1'b0;
    else if (resetLvl)               exhausted <= 1'b0;
    else if (strobes.advance && atLast) exhausted <= 1'b1;
  end

  assign driveEn = readSel & ~exhausted;
  assign ceoN    = ~(readSel & exhausted);
endmodule

// File: rtl/cfg_bit_reader.sv
module cfg_bit_reader
  import cfg_bit_reader_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstActiveHigh,
  input  logic              rstOePin,
  input  logic              ceN,
  input  logic              serEn,
  input  logic              prgWe,
  input  logic [ADDR_W-1:0] prgAddr,
  input  logic              prgBit,
  output logic              dataOut,
  output logic              dataOe,
  output logic              ceoN
);
  ctlStrobes_t       strobes;
  logic [ADDR_W-1:0] bitPos;
  logic              atLast;
  logic              curBit;
  logic              driveEn;

  cfg_bit_reader_ctl i_ctl (
    .clk(clk), .porN(porN), .rstActiveHigh(rstActiveHigh), .rstOePin(rstOePin),
    .ceN(ceN), .serEn(serEn), .atLast(atLast),
    .strobes(strobes), .driveEn(driveEn), .ceoN(ceoN)
  );

  cfg_bit_reader_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_dp (
    .clk(clk), .porN(porN), .strobes(strobes), .progMode(~serEn),
    .prgWe(prgWe), .prgAddr(prgAddr), .prgBit(prgBit),
    .bitPos(bitPos), .atLast(atLast), .curBit(curBit)
  );

  assign dataOe  = driveEn;
  assign dataOut = driveEn & curBit;
endmodule

// File: rtl/cfg_bit_reader_chk.sv
module cfg_bit_reader_chk #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input logic              clk,
  input logic              porN,
  input logic              rstActiveHigh,
  input logic              rstOePin,
  input logic              ceN,
  input logic              serEn,
  input logic              dataOe,
  input logic              ceoN,
  input logic [ADDR_W-1:0] bitPos
);
  localparam logic [ADDR_W-1:0] LAST_POS = ADDR_W'(DEPTH - 1);
  logic rstHit;
  assign rstHit = rstActiveHigh ? rstOePin : ~rstOePin;

  assert_reset_quiet_R2: assert property (@(posedge clk) disable iff (!porN)
    rstHit |-> (!dataOe && ceoN));
  assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!porN)
    rstHit |=> (bitPos == '0));
  assert_ce_quiet_R5: assert property (@(posedge clk) disable iff (!porN)
    ceN |-> !dataOe);
  assert_ce_freeze_R5: assert property (@(posedge clk) disable iff (!porN)
    (ceN && !rstHit) |=> $stable(bitPos));
  assert_step_R4: assert property (@(posedge clk) disable iff (!porN)
    (dataOe && bitPos != LAST_POS) |=> (bitPos == ADDR_W'($past(bitPos) + 1'b1)));
  assert_handoff_R7: assert property (@(posedge clk) disable iff (!porN)
    !ceoN |-> !dataOe);
  assert_ceo_follow_R8: assert property (@(posedge clk) disable iff (!porN)
    !ceoN |-> (!ceN && !rstHit && serEn));
  assert_prog_quiet_R9: assert property (@(posedge clk) disable iff (!porN)
    !serEn |-> (!dataOe && ceoN));
  assert_prog_freeze_R9: assert property (@(posedge clk) disable iff (!porN)
    (!serEn && !rstHit) |=> $stable(bitPos));
endmodule

bind cfg_bit_reader cfg_bit_reader_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .porN(porN), .rstActiveHigh(rstActiveHigh), .rstOePin(rstOePin),
  .ceN(ceN), .serEn(serEn), .dataOe(dataOe), .ceoN(ceoN), .bitPos(bitPos)
);

// File: tb/test_cfg_bit_reader.sv
`timescale 1ns/1ps
module test_cfg_bit_reader;
  localparam int DEPTH  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic rstActiveHigh = 1'b0;
  logic rstOePin = 1'b0;
  logic ceN = 1'b1;
  logic serEn = 1'b0;
  logic prgWe = 1'b0;
  logic [ADDR_W-1:0] prgAddr = '0;
  logic prgBit = 1'b0;
  logic dataOut, dataOe, ceoN;

  int nVec = 0;
  int nBad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cfg_bit_reader #(.DEPTH(DEPTH)) i_cfg_bit_reader (
    .clk(clk), .porN(porN), .rstActiveHigh(rstActiveHigh), .rstOePin(rstOePin),
    .ceN(ceN), .serEn(serEn), .prgWe(prgWe), .prgAddr(prgAddr), .prgBit(prgBit),
    .dataOut(dataOut), .dataOe(dataOe), .ceoN(ceoN)
  );

  function automatic logic patBit(int i);
    logic [31:0] v;
    v = ((i * 11) >> 2) ^ i;
    return v[0];
  endfunction

  typedef struct packed {
    logic       ce;
    logic       pin;
    logic       ser;
    logic       expOe;
    logic [3:0] idx;
    logic       expCeo;
    logic [3:0] req;
  } vec_t;

  // Polarity default: pin low = reset, pin high = output enabled
  localparam vec_t VEC [13] = '{
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd2},  // R2 reset level
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd0, 1'b1, 4'd5},  // R5 deselected
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b1, 4'd6},  // R6 first bit
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 1'b1, 4'd4},  // R4 step
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd2, 1'b1, 4'd5},  // R5 freeze
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd2, 1'b1, 4'd5},  // R5 resumes where held
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd3, 1'b1, 4'd4},  // R4
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd2},  // R2 reset while selected
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'd0, 1'b1, 4'd2},  // R2 reset while deselected
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 1'b1, 4'd2},  // R2 restarted at 0
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 4'd9},  // R9 programming mode
    '{1'b1, 1'b1, 1'b0, 1'b0, 4'd1, 1'b1, 4'd9},  // R9 CE no effect
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd1, 1'b1, 4'd9}   // R9 counter held
  };

  task automatic apply(logic ce, logic pin, logic ser);
    @(negedge clk);
    ceN = ce; rstOePin = pin; serEn = ser;
    #1;
  endtask

  task automatic chk(int req, logic eOe, logic eBit, logic eCeo);
    nVec++;
    if (dataOe !== eOe || ceoN !== eCeo || (eOe && dataOut !== eBit)) begin
      nBad++;
      $display("FAIL R%0d: oe=%b data=%b ceo=%b expected oe=%b data=%b ceo=%b",
               req, dataOe, dataOut, ceoN, eOe, eBit, eCeo);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    // Power-on reset, then preload in programming mode
    repeat (2) @(negedge clk);
    porN = 1'b1;
    rstOePin = 1'b1;
    ceN = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      prgWe = 1'b1; prgAddr = ADDR_W'(i); prgBit = patBit(i);
    end
    @(negedge clk);
    prgWe = 1'b0;

    // Vector table walk
    foreach (VEC[k]) begin
      apply(VEC[k].ce, VEC[k].pin, VEC[k].ser);
      chk(int'(VEC[k].req), VEC[k].expOe, patBit(int'(VEC[k].idx)), VEC[k].expCeo);
    end

    // R7: full read-out, then handoff
    apply(1'b0, 1'b0, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      apply(1'b0, 1'b1, 1'b1);
      chk(6, 1'b1, patBit(i), 1'b1);  // R6 each stored bit in order
    end
    apply(1'b0, 1'b1, 1'b1);
    chk(7, 1'b0, 1'b0, 1'b0);  // R7 released, chain output low
    // R8: follow CE, then release on reset level
    apply(1'b1, 1'b1, 1'b1);
    chk(8, 1'b0, 1'b0, 1'b1);
    apply(1'b0, 1'b1, 1'b1);
    chk(8, 1'b0, 1'b0, 1'b0);
    apply(1'b0, 1'b1, 1'b1);
    chk(8, 1'b0, 1'b0, 1'b0);
    apply(1'b0, 1'b0, 1'b1);
    chk(8, 1'b0, 1'b0, 1'b1);
    apply(1'b0, 1'b1, 1'b1);
    chk(8, 1'b1, patBit(0), 1'b1);  // R8 high again, read restarts

    // R3: inverted pin sense
    @(negedge clk);
    rstActiveHigh = 1'b1;
    apply(1'b0, 1'b1, 1'b1);
    chk(3, 1'b0, 1'b0, 1'b1);
    apply(1'b0, 1'b0, 1'b1);
    chk(3, 1'b1, patBit(0), 1'b1);
    apply(1'b0, 1'b0, 1'b1);
    chk(3, 1'b1, patBit(1), 1'b1);
    @(negedge clk);
    rstActiveHigh = 1'b0;

    // R9: write in read mode is ignored
    apply(1'b1, 1'b1, 1'b1);
    prgWe = 1'b1; prgAddr = '0; prgBit = ~patBit(0);
    @(negedge clk);
    prgWe = 1'b0;
    apply(1'b0, 1'b0, 1'b1);
    apply(1'b0, 1'b1, 1'b1);
    chk(9, 1'b1, patBit(0), 1'b1);

    // R1: power-on reset mid-read
    apply(1'b0, 1'b1, 1'b1);
    apply(1'b0, 1'b1, 1'b1);
    chk(1, 1'b1, patBit(2), 1'b1);
    @(negedge clk);
    porN = 1'b0;
    @(negedge clk);
    porN = 1'b1;
    ceN = 1'b1;
    apply(1'b0, 1'b1, 1'b1);
    chk(1, 1'b1, patBit(0), 1'b1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule